// File: doc/BRIEF.md
# Polynomial Sequence Self-Test Checker

This block runs the pattern check of a random generator's health test. A small internal buffer of wide words, loaded beforehand with words captured from the generator in a diagnostic mode, is scanned against a pseudo-random reference sequence. The reference sequence starts at a fixed seed. Each step shifts the value one bit to the left. When the bit leaving the top was a one, the value is also XORed with a fixed polynomial constant.

One iteration compares every buffer slot except slot 0 with the current reference value, one slot per clock. It adds the number of equal slots to a running total that is carried from one iteration to the next. If the total has reached the match goal after a scan, the test passes. Otherwise the reference value advances by exactly one step and the scan repeats. If the iteration limit runs out before the goal is met, the test fails.

The load port is a valid/ready stream. A word is taken on a clock edge where `wr_valid` and `wr_ready` are both high. `wr_ready` is low for the whole of a running test, so a producer that keeps `wr_valid` high simply waits, and nothing it offers reaches the buffer during that time. Start, busy, done, pass and the loop count are plain level or pulse pins.

Top module: `polyseq_selftest`

## Requirements
- R1: After reset, `busy`, `done` and `pass` are low, `loops_used` is 0 and `wr_ready` is high.
- R2: A word is stored in slot `wr_slot` on a clock edge with `wr_valid` and `wr_ready` both high. `wr_ready` is low while `busy` is high, and words offered in that time are never stored.
- R3: Iteration k (counted from 0) compares the slots with the seed advanced by k steps. One step is a left shift by one bit with a 0 shifted in, followed by an XOR with the polynomial when the bit shifted out was 1.
- R4: Slot 0 is never compared. Slots 1 to DEPTH-1 are each compared once per iteration, so a match in the last slot counts.
- R5: Matches accumulate across iterations. After a scan whose running total is at least MATCH_GOAL, the test ends with `pass` high and `loops_used` equal to that iteration's index k.
- R6: If MATCH_GOAL has not been reached after LOOP_MAX iterations, the test ends with `pass` low and `loops_used` equal to LOOP_MAX.
- R7: `busy` rises on the clock edge that accepts `start`. `done` is high after exactly N*(DEPTH-1) further edges, where N is the number of iterations run (k+1 on pass, LOOP_MAX on fail). `busy` falls on that same edge.
- R8: `done` is high for one cycle. `pass` and `loops_used` hold their values until the next accepted `start`, which clears both to 0.
- R9: A `start` that arrives while `busy` is high is ignored: the running test continues and ends as if the pulse had never come.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Load word offered |
| wr_ready | output | 1 | Buffer can take a word (idle) |
| wr_slot | input | IDX_W | Buffer slot to write |
| wr_data | input | W | Word to store |
| start | input | 1 | Begin a test when idle |
| busy | output | 1 | Test running |
| done | output | 1 | One-cycle end-of-test pulse |
| pass | output | 1 | Result of the last test |
| loops_used | output | LOOP_W | Iteration index at pass, or LOOP_MAX at fail |

## Verification
The bench places reference values at chosen slots and sequence positions to reach the edges of the scan. One case puts a reference word only in slot 0, which a design that scanned slot 0 would count as a pass. Another puts a match in the last slot, which an off-by-one scan would miss. A match at the final allowed iteration is set beside one just beyond the limit, which catches a loop bound that is off by one. A case with several matches of a single value would show a design that counted at most one match per iteration. Start pulses and load writes issued during a run would, in a design that obeyed them, restart the test or change the buffer. The bench detects this through a wrong latency or a changed result on the next run.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic {
    PST_IDLE = 1'b0,
    PST_SCAN = 1'b1
  } pst_state_e;
endpackage

// File: rtl/pst_buf.sv
module pst_buf #(
  parameter int W     = 64,
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_slot,
  input  logic [W-1:0]     wr_data,
  input  logic [IDX_W-1:0] rd_slot,
  output logic [W-1:0]     rd_data
);
  logic [W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem_q[g] <= '0;
      else if (we && (wr_slot == IDX_W'(g)))
        mem_q[g] <= wr_data;
    end
  end

  assign rd_data = mem_q[rd_slot];
endmodule

// File: rtl/pst_step.sv
module pst_step #(
  parameter int           W    = 64,
  parameter logic [W-1:0] POLY = '0
) (
  input  logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic [W-1:0] shifted;

  always_comb begin
    shifted = {cur[W-2:0], 1'b0};
    nxt     = cur[W-1] ? (shifted ^ POLY) : shifted;
  end
endmodule

// File: rtl/pst_ctrl.sv
module pst_ctrl
  import pst_pkg::*;
#(
  parameter int           W          = 64,
  parameter int           DEPTH      = 8,
  parameter int           MATCH_GOAL = 2,
  parameter int           LOOP_MAX   = 16,
  parameter logic [W-1:0] SEED       = '1,
  parameter int           IDX_W      = 3,
  parameter int           LOOP_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              hit,
  input  logic [W-1:0]      exp_nxt,
  output logic [W-1:0]      exp_q,
  output logic [IDX_W-1:0]  slot_q,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [LOOP_W-1:0] loops_used
);
  localparam int CNT_W = $clog2((DEPTH - 1) * LOOP_MAX + MATCH_GOAL + 1);
  localparam logic [IDX_W-1:0]  LAST_SLOT = IDX_W'(DEPTH - 1);
  localparam logic [LOOP_W-1:0] LAST_ITER = LOOP_W'(LOOP_MAX - 1);
  localparam logic [CNT_W-1:0]  GOAL      = CNT_W'(MATCH_GOAL);

  pst_state_e        state_q;
  logic [CNT_W-1:0]  total_q;
  logic [CNT_W-1:0]  total_now;
  logic [LOOP_W-1:0] iter_q;

  assign total_now = total_q + CNT_W'(hit);
  assign busy      = (state_q == PST_SCAN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= PST_IDLE;
      total_q    <= '0;
      iter_q     <= '0;
      slot_q     <= IDX_W'(1);
      exp_q      <= SEED;
      done       <= 1'b0;
      pass       <= 1'b0;
      loops_used <= '0;
    end else begin
      done <= 1'b0;
      case (state_q)
        PST_IDLE: begin
          if (start) begin
            state_q    <= PST_SCAN;
            total_q    <= '0;
            iter_q     <= '0;
            slot_q     <= IDX_W'(1);
            exp_q      <= SEED;
            pass       <= 1'b0;
            loops_used <= '0;
          end
        end
        PST_SCAN: begin
          total_q <= total_now;
          if (slot_q != LAST_SLOT) begin
            slot_q <= slot_q + IDX_W'(1);
          end else if (total_now >= GOAL) begin
            state_q    <= PST_IDLE;
            done       <= 1'b1;
            pass       <= 1'b1;
            loops_used <= iter_q;
          end else if (iter_q == LAST_ITER) begin
            state_q    <= PST_IDLE;
            done       <= 1'b1;
            pass       <= 1'b0;
            loops_used <= LOOP_W'(LOOP_MAX);
          end else begin
            iter_q <= iter_q + LOOP_W'(1);
            slot_q <= IDX_W'(1);
            exp_q  <= exp_nxt;
          end
        end
        default: state_q <= PST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/polyseq_selftest.sv
module polyseq_selftest #(
  parameter int           W          = 64,
  parameter int           DEPTH      = 8,
  parameter int           MATCH_GOAL = 2,
  parameter int           LOOP_MAX   = 16,
  parameter logic [W-1:0] SEED       = 64'h9E37_79B9_7F4A_7C15,
  parameter logic [W-1:0] POLY       = 64'h231D_CEE9_1262_B8A3,
  localparam int          IDX_W      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int          LOOP_W     = $clog2(LOOP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic [W-1:0]      wr_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [LOOP_W-1:0] loops_used
);
  logic [W-1:0]     exp_q;
  logic [W-1:0]     exp_nxt;
  logic [W-1:0]     rd_data;
  logic [IDX_W-1:0] slot_q;
  logic             hit;

  assign wr_ready = !busy;
  assign hit      = (rd_data == exp_q);

  pst_buf #(.W(W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (wr_valid && wr_ready),
    .wr_slot (wr_slot),
    .wr_data (wr_data),
    .rd_slot (slot_q),
    .rd_data (rd_data)
  );

  pst_step #(.W(W), .POLY(POLY)) u_step (
    .cur (exp_q),
    .nxt (exp_nxt)
  );

  pst_ctrl #(
    .W(W), .DEPTH(DEPTH), .MATCH_GOAL(MATCH_GOAL), .LOOP_MAX(LOOP_MAX),
    .SEED(SEED), .IDX_W(IDX_W), .LOOP_W(LOOP_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .hit        (hit),
    .exp_nxt    (exp_nxt),
    .exp_q      (exp_q),
    .slot_q     (slot_q),
    .busy       (busy),
    .done       (done),
    .pass       (pass),
    .loops_used (loops_used)
  );
endmodule

// File: rtl/pst_chk.sv
module pst_chk #(
  parameter int LOOP_MAX = 16,
  parameter int LOOP_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              wr_ready,
  input logic              busy,
  input logic              done,
  input logic              pass,
  input logic [LOOP_W-1:0] loops_used
);
  a_r2_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_ready);

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_pass_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(pass) && $stable(loops_used));

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r9_run_continues: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  a_r5_pass_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pass) |-> done);

  a_r6_loops_bound: assert property (@(posedge clk) disable iff (!rst_n)
    loops_used <= LOOP_W'(LOOP_MAX));
endmodule

bind polyseq_selftest pst_chk #(.LOOP_MAX(LOOP_MAX), .LOOP_W(LOOP_W)) u_pst_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .wr_ready   (wr_ready),
  .busy       (busy),
  .done       (done),
  .pass       (pass),
  .loops_used (loops_used)
);

// File: tb/test_polyseq_selftest.sv
`timescale 1ns/1ps
module test_polyseq_selftest;
  localparam int          W        = 64;
  localparam int          DEPTH    = 8;
  localparam int          GOAL     = 2;
  localparam int          LMAX     = 16;
  localparam logic [W-1:0] SEED    = 64'h9E37_79B9_7F4A_7C15;
  localparam logic [W-1:0] POLY    = 64'h231D_CEE9_1262_B8A3;
  localparam int          FILL     = 255;
  localparam int          NV       = 8;

  // columns: slot0..slot7 sequence index (FILL = zero word), exp pass, exp loops
  localparam int VT [NV][10] = '{
    '{FILL, 0,    0,    FILL, FILL, FILL, FILL, FILL, 1, 0 },  // R5 goal in first scan
    '{FILL, 3,    FILL, 5,    FILL, FILL, FILL, FILL, 1, 5 },  // R3 R5 accumulate
    '{FILL, FILL, FILL, FILL, FILL, FILL, FILL, FILL, 0, 16},  // R6 nothing
    '{0,    0,    15,   FILL, FILL, FILL, FILL, FILL, 1, 15},  // R4 slot0 skipped, last iteration
    '{FILL, 2,    FILL, FILL, FILL, FILL, FILL, 2,    1, 2 },  // R4 last slot
    '{FILL, 16,   16,   FILL, FILL, FILL, FILL, FILL, 0, 16},  // R6 just past limit
    '{FILL, 4,    4,    4,    FILL, FILL, FILL, FILL, 1, 4 },  // R5 multiple hits per scan
    '{1,    1,    FILL, FILL, FILL, FILL, FILL, FILL, 0, 16}   // R4 slot0 would give pass
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_valid = 1'b0;
  logic         wr_ready;
  logic [2:0]   wr_slot = '0;
  logic [W-1:0] wr_data = '0;
  logic         start = 1'b0;
  logic         busy, done, pass;
  logic [4:0]   loops_used;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  polyseq_selftest #(
    .W(W), .DEPTH(DEPTH), .MATCH_GOAL(GOAL), .LOOP_MAX(LMAX), .SEED(SEED), .POLY(POLY)
  ) i_polyseq_selftest (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_slot(wr_slot), .wr_data(wr_data), .start(start), .busy(busy),
    .done(done), .pass(pass), .loops_used(loops_used)
  );

  function automatic logic [W-1:0] seq_val(int k);
    logic [W-1:0] v = SEED;
    for (int i = 0; i < k; i++) begin
      logic top = v[W-1];
      v = v << 1;
      if (top) v = v ^ POLY;
    end
    return v;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic write_word(int slot, logic [W-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_slot  = slot[2:0];
    wr_data  = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic load_vec(int v);
    for (int s = 0; s < DEPTH; s++)
      write_word(s, (VT[v][s] == FILL) ? '0 : seq_val(VT[v][s]));
  endtask

  task automatic run_test(bit exp_pass, int exp_loops, int restart_at, bit poke, string tag);
    int cyc = 0;
    int iters = exp_pass ? exp_loops + 1 : LMAX;
    bit ready_bad = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, {tag, " R7 busy after start"}, busy, 1);
    chk(pass == 1'b0 && loops_used == 0, {tag, " R8 result cleared at start"}, pass, 0);
    if (poke) begin
      wr_valid = 1'b1;
      wr_slot  = 3'd1;
      wr_data  = seq_val(0);
    end
    while (!done && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      start = (restart_at != 0 && cyc == restart_at);
      if (busy && wr_ready) ready_bad = 1'b1;
      if (poke) wr_slot = (cyc % 2 == 0) ? 3'd1 : 3'd2;
    end
    wr_valid = 1'b0;
    start    = 1'b0;
    if (poke) chk(!ready_bad, {tag, " R2 wr_ready low while busy"}, ready_bad, 0);
    chk(cyc == iters * (DEPTH - 1), {tag, " R7 latency"}, cyc, iters * (DEPTH - 1));
    chk(busy == 1'b0, {tag, " R7 busy falls with done"}, busy, 0);
    chk(pass == exp_pass, {tag, " pass"}, pass, exp_pass);
    chk(loops_used == exp_loops, {tag, " loops_used"}, loops_used, exp_loops);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R8 done one cycle"}, done, 0);
    chk(pass == exp_pass && loops_used == exp_loops, {tag, " R8 result held"}, pass, exp_pass);
  endtask

  initial begin
    #(20ns * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0 && pass == 0, "R1 flags at reset", {busy, done, pass}, 0);
    chk(loops_used == 0, "R1 loops_used at reset", loops_used, 0);
    chk(wr_ready == 1, "R1 wr_ready at reset", wr_ready, 1);
    rst_n = 1'b1;

    // table walk: R2 loading, R3 sequence, R4 slot range, R5 pass, R6 fail, R7 latency
    for (int v = 0; v < NV; v++) begin
      load_vec(v);
      run_test(VT[v][8] != 0, VT[v][9], 0, 1'b0, $sformatf("vec%0d R3 R4 R5 R6", v));
    end

    // R9 start during a run is ignored
    load_vec(1);
    run_test(1'b1, 5, 10, 1'b0, "R9 restart ignored");

    // R2 writes offered while busy are not stored
    load_vec(2);
    run_test(1'b0, 16, 0, 1'b1, "R2 poke run");
    run_test(1'b0, 16, 0, 1'b0, "R2 buffer unchanged");

    // R2 write accepted when idle changes the outcome
    write_word(1, seq_val(0));
    write_word(2, seq_val(0));
    run_test(1'b1, 0, 0, 1'b0, "R2 idle write taken");

    // R8 pass cleared by a new start even when the new test fails
    load_vec(5);
    run_test(1'b0, 16, 0, 1'b0, "R8 pass to fail");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule